// File: doc/BRIEF.md
# Two-Channel Converter Data Front End

This block sits in front of a pair of 14-bit converter cores. It accepts parallel data words and presents two registered output codes, one for each core. All control inputs are treated as synchronous levels. One fast system clock samples them, and the block acts on their rising transitions. The strobes and clocks of the input side therefore need no clock domains of their own.

A mode input chooses between two ways of feeding the cores:

- **Dual-port mode.** Each channel has its own data bus, its own capture strobe and its own update clock. The two channels run independently.
- **Interleaved mode.** A single bus carries alternating I and Q words. A select line steers each word to one channel. An internal divide-by-two of the shared update clock then refreshes both outputs together, at half the word rate. A freeze input can hold that divider.

Two control pins change their meaning with the mode. The second channel's update clock becomes the freeze input, and its capture strobe becomes the I/Q select.

Top module: `iq_dac_front`

## Requirements
- R1: A synchronous active-high `rst` clears both output codes to 0, both valid flags to 0, both holding registers to 0 and the divider phase.
- R2: In dual-port mode (`dual_mode`=1), a rising edge of a channel's capture strobe copies that channel's bus into its holding register. The channel's output code does not change until that channel's update clock rises.
- R3: In dual-port mode, a rising edge of a channel's update clock copies its holding register to its output code in the following cycle. The other channel's output is not affected.
- R4: Capture acts only on a rising transition. A strobe held high does not take in later bus values.
- R5: In interleaved mode (`dual_mode`=0), a rising edge of `wstb_a` captures `a_data`. The word goes to channel A when `wstb_b_sel`=1 and to channel B when `wstb_b_sel`=0. `b_data` is ignored.
- R6: In interleaved mode, `uclk_a` is divided by two. Both outputs load from their holding registers together on the first rising edge after reset, after entering interleaved mode or after the freeze input is released, and then on every second rising edge. On the other rising edges the outputs stay unchanged.
- R7: While `uclk_b_frz` is high in interleaved mode, rising edges of `uclk_a` have no effect. The outputs stay unchanged and the divider is held cleared.
- R8: Each valid flag rises with its channel's first output load after reset and stays high until the next reset.
- R9: In interleaved mode, `wstb_b_sel` may change only in a cycle where both `wstb_a` and `uclk_a` are low.
- R10: Codes are straight binary with bit 13 as the MSB. Code 0 (zero scale), code 8192 (half scale) and code 16383 (full scale) pass to the outputs unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control level |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 selects dual-port mode, 0 selects interleaved mode |
| a_data | input | 14 | Channel A bus; in interleaved mode, the shared I/Q bus |
| b_data | input | 14 | Channel B bus; ignored in interleaved mode |
| wstb_a | input | 1 | Channel A capture strobe; shared capture strobe in interleaved mode |
| uclk_a | input | 1 | Channel A update clock; shared update clock in interleaved mode |
| uclk_b_frz | input | 1 | Channel B update clock; divider freeze in interleaved mode |
| wstb_b_sel | input | 1 | Channel B capture strobe; I/Q select in interleaved mode (1 = A, 0 = B) |
| code_a | output | 14 | Registered code for converter core A |
| code_b | output | 14 | Registered code for converter core B |
| valid_a | output | 1 | High once channel A has loaded a code since reset |
| valid_b | output | 1 | High once channel B has loaded a code since reset |

## Verification
A wrong divider phase shows up at the next shared clock rise. The outputs then change on the wrong rise, or on no rise at all, so the scoreboard sees a word arrive early, late or missing. A misrouted select, or a bus B that leaks into interleaved mode, puts the wrong word into a holding register. That error shows at the very next load, where the code at the port differs from the expected entry. A stale edge detector either misses a strobe or re-captures a held one. It shows within one update, either as an unchanged output or as a word the driver never queued.

// File: rtl/iq_dac_front.sv
module iq_dac_front #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dual_mode,
  input  logic [W-1:0] a_data,
  input  logic [W-1:0] b_data,
  input  logic         wstb_a,
  input  logic         uclk_a,
  input  logic         uclk_b_frz,
  input  logic         wstb_b_sel,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b,
  output logic         valid_a,
  output logic         valid_b
);

  logic [3:0]   pins_q;
  logic [W-1:0] hold_a, hold_b;
  logic         phase;

  wire [3:0] pins = {wstb_a, uclk_a, uclk_b_frz, wstb_b_sel};
  wire [3:0] rise = pins & ~pins_q;

  wire il      = ~dual_mode;
  wire frz     = il & uclk_b_frz;
  wire il_cap  = il & rise[3];
  wire il_tick = il & rise[2] & ~frz;
  wire il_load = il_tick & ~phase;

  wire cap_a  = dual_mode ? rise[3] : (il_cap & wstb_b_sel);
  wire cap_b  = dual_mode ? rise[0] : (il_cap & ~wstb_b_sel);
  wire load_a = dual_mode ? rise[2] : il_load;
  wire load_b = dual_mode ? rise[1] : il_load;

  wire [W-1:0] word_b = dual_mode ? b_data : a_data;

  always_ff @(posedge clk) begin
    pins_q <= pins;
    if (rst) begin
      hold_a  <= '0;
      hold_b  <= '0;
      code_a  <= '0;
      code_b  <= '0;
      valid_a <= 1'b0;
      valid_b <= 1'b0;
      phase   <= 1'b0;
    end else begin
      if (cap_a) hold_a <= a_data;
      if (cap_b) hold_b <= word_b;
      if (load_a) begin
        code_a  <= hold_a;
        valid_a <= 1'b1;
      end
      if (load_b) begin
        code_b  <= hold_b;
        valid_b <= 1'b1;
      end
      if (dual_mode || frz) phase <= 1'b0;
      else if (il_tick)     phase <= ~phase;
    end
  end

endmodule

// File: rtl/iq_dac_front_chk.sv
module iq_dac_front_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         dual_mode,
  input logic [W-1:0] a_data,
  input logic [W-1:0] b_data,
  input logic         wstb_a,
  input logic         uclk_a,
  input logic         uclk_b_frz,
  input logic         wstb_b_sel,
  input logic [W-1:0] code_a,
  input logic [W-1:0] code_b,
  input logic         valid_a,
  input logic         valid_b
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0 && !valid_a && !valid_b));

  p_dual_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !(uclk_a && !$past(uclk_a))) |=> $stable(code_a));

  p_dual_hold_b_r3: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !(uclk_b_frz && !$past(uclk_b_frz))) |=> $stable(code_b));

  p_il_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !(uclk_a && !$past(uclk_a))) |=> ($stable(code_a) && $stable(code_b)));

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && uclk_b_frz) |=> ($stable(code_a) && $stable(code_b)));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_a && valid_b) |=> (valid_a && valid_b));

  p_valid_a_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    valid_a |=> valid_a);

  p_sel_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && (wstb_b_sel != $past(wstb_b_sel))) |-> (!wstb_a && !uclk_a));

endmodule

bind iq_dac_front iq_dac_front_chk #(.W(W)) u_chk (.*);

// File: tb/iq_dac_front_bench.sv
module iq_dac_front_bench;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dual_mode = 1'b1;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic         wstb_a = 0, uclk_a = 0, uclk_b_frz = 0, wstb_b_sel = 0;
  logic [W-1:0] code_a, code_b;
  logic         valid_a, valid_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] exp_a[$];
  logic [W-1:0] exp_b[$];

  always #4 clk = ~clk;

  iq_dac_front #(.W(W)) u_iq_dac_front (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // scoreboard monitor
  logic [W-1:0] last_a = '0, last_b = '0;
  logic         last_va = 0, last_vb = 0;
  always @(negedge clk) begin
    if (rst) begin
      last_a <= '0; last_b <= '0; last_va <= 0; last_vb <= 0;
    end else begin
      if (code_a != last_a || (valid_a && !last_va)) begin
        if (exp_a.size() == 0) chk(0, "R3 unexpected load A", code_a, -1);
        else begin
          logic [W-1:0] e;
          e = exp_a.pop_front();
          chk(code_a == e, "R3/R6 code_a order", code_a, e);
        end
      end
      if (code_b != last_b || (valid_b && !last_vb)) begin
        if (exp_b.size() == 0) chk(0, "R3 unexpected load B", code_b, -1);
        else begin
          logic [W-1:0] e;
          e = exp_b.pop_front();
          chk(code_b == e, "R3/R6 code_b order", code_b, e);
        end
      end
      last_a <= code_a; last_b <= code_b; last_va <= valid_a; last_vb <= valid_b;
    end
  end

  task automatic do_reset();
    rst = 1; tick(); tick(); tick(); rst = 0; tick();
  endtask

  task automatic dual_write(input bit ch_b, input logic [W-1:0] w);
    if (ch_b) begin b_data = w; wstb_b_sel = 1; end
    else      begin a_data = w; wstb_a = 1; end
    tick();
    wstb_a = 0; wstb_b_sel = 0; tick();
  endtask

  task automatic dual_update(input bit do_a, input bit do_b,
                             input logic [W-1:0] ea, input logic [W-1:0] eb);
    if (do_a) exp_a.push_back(ea);
    if (do_b) exp_b.push_back(eb);
    uclk_a = do_a; uclk_b_frz = do_b; tick();
    uclk_a = 0; uclk_b_frz = 0; tick();
  endtask

  task automatic iq_write(input bit sel, input logic [W-1:0] w);
    wstb_b_sel = sel; tick();
    a_data = w; b_data = ~w; wstb_a = 1; tick();
    wstb_a = 0; tick();
  endtask

  task automatic iq_tick(input bit load, input logic [W-1:0] ea, input logic [W-1:0] eb);
    if (load) begin exp_a.push_back(ea); exp_b.push_back(eb); end
    uclk_a = 1; tick();
    uclk_a = 0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk(code_a == 0 && code_b == 0, "R1 codes after reset", code_a, 0);
    chk(!valid_a && !valid_b, "R1 valid after reset", valid_a, 0);

    // R2: capture does not move output
    dual_write(0, 14'h1234);
    chk(code_a == 0, "R2 code_a waits for update", code_a, 0);
    chk(!valid_a, "R2 valid_a before update", valid_a, 0);

    // R4: strobe held high, bus changes
    a_data = 14'h0ABC; wstb_a = 1; tick();
    a_data = 14'h0DEF; tick(); tick();
    wstb_a = 0; tick();
    dual_update(1, 0, 14'h0ABC, 0);
    chk(code_a == 14'h0ABC, "R4 held strobe ignores later bus", code_a, 14'h0ABC);
    // R8 only A has loaded
    chk(valid_a && !valid_b, "R8 valid only on loaded channel", {valid_a, valid_b}, 2);

    // R3: channel B independent
    dual_write(1, 14'd8192);
    dual_update(0, 1, 0, 14'd8192);
    chk(code_b == 14'd8192, "R3 code_b half scale (R10)", code_b, 8192);
    chk(code_a == 14'h0ABC, "R3 code_a untouched by B update", code_a, 14'h0ABC);
    chk(valid_a && valid_b, "R8 both valid", {valid_a, valid_b}, 3);

    // R10 full scale and zero, simultaneous update
    dual_write(0, 14'd16383);
    dual_write(1, 14'd0);
    dual_update(1, 1, 14'd16383, 14'd0);
    chk(code_a == 14'd16383, "R10 full scale", code_a, 16383);
    chk(code_b == 14'd0, "R10 zero scale", code_b, 0);

    // interleaved mode
    dual_mode = 0; tick();
    iq_write(1, 14'h0111);
    iq_write(0, 14'h0222);
    chk(code_a == 14'd16383 && code_b == 0, "R5 capture alone no load", code_a, 16383);
    iq_tick(1, 14'h0111, 14'h0222);
    chk(code_a == 14'h0111, "R6 first rise loads A", code_a, 14'h0111);
    chk(code_b == 14'h0222, "R5 B from bus A not bus B", code_b, 14'h0222);
    iq_write(1, 14'h0333);
    iq_write(0, 14'h0444);
    iq_tick(0, 0, 0);
    chk(code_a == 14'h0111 && code_b == 14'h0222, "R6 second rise no load", code_a, 14'h0111);
    iq_tick(1, 14'h0333, 14'h0444);
    chk(code_a == 14'h0333 && code_b == 14'h0444, "R6 third rise loads", code_b, 14'h0444);

    // R7 freeze after odd number of rises
    uclk_b_frz = 1; tick();
    iq_write(1, 14'h0555);
    iq_write(0, 14'h0666);
    iq_tick(0, 0, 0);
    iq_tick(0, 0, 0);
    chk(code_a == 14'h0333 && code_b == 14'h0444, "R7 frozen outputs hold", code_a, 14'h0333);
    uclk_b_frz = 0; tick();
    iq_tick(1, 14'h0555, 14'h0666);
    chk(code_a == 14'h0555 && code_b == 14'h0666, "R7 first rise after release loads", code_a, 14'h0555);
    iq_tick(0, 0, 0);
    chk(code_a == 14'h0555, "R6 next rise after release no load", code_a, 14'h0555);

    // R1 mid-run reset
    wstb_b_sel = 0; tick();
    do_reset();
    chk(code_a == 0 && code_b == 0 && !valid_a && !valid_b, "R1 reset mid-run", code_a, 0);
    chk(exp_a.size() == 0 && exp_b.size() == 0, "R6 scoreboard drained",
        exp_a.size() + exp_b.size(), 0);
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule